// File: doc/BRIEF.md
# Ethernet PHY Status LED Controller

This block drives a set of status LEDs (four by default) for a tri-speed Ethernet PHY. Every LED has two 8-bit configuration registers. One picks the condition that holds the LED steadily lit and the condition that makes it blink at the fast rate. The other picks the condition for slow blinking and a mask of traffic events that briefly flip the LED. Conditions come from one shared 4-bit code. The code covers combinations of link speed (10, 100 and 1000 Mbit/s) and a set of PHY states: powered down, energy-efficient mode, auto-negotiation, analog self-test and cable diagnostics.

A global register selects the fast and the slow blink rates from 2, 4, 8 and 16 Hz for all LEDs at once. Both rates come from one free-running prescaler that is derived from the clock frequency parameter, so every LED blinks in phase. Single-cycle transmit, receive and collision strobes are stretched into pulses of a parameterized length. A plain write and read port, with combinational read data, loads and returns the configuration.

Top module: `phy_led_ctrl`

## Requirements
- R1: After reset the registers read as follows. Global is 0x00C5. The LED high and low registers are: LED0 0x70/0x03, LED1 0x20/0x00, LED2 0x40/0x00, LED3 0x40/0x20. LED n reuses the values of LED n mod 4.
- R2: The address map places global at 0 and LED n at 1+2n (high) and 2+2n (low). Bits 15:8 of every register read as zero, and global bit 3 reads as zero. Addresses outside the map read zero, and writes to them change nothing. Global bits 7:6 select the fast rate, 5:4 the slow rate, and 2:0 are stored but have no function.
- R3: The high register holds the constant-on code in bits 7:4 and the fast-blink code in bits 3:0. The low register holds the slow-blink code in bits 7:4 and the pulse mask in bits 3:0. Codes: 0 never. 1 link at 10. 2 link at 100. 3 link at 10 or 100. 4 link at 1000. 5 link at 10 or 1000. 6 link at 100 or 1000. 7 link at any speed. 8 powered down. 9 energy-efficient mode. 10 auto-negotiation. 11 self-test. 12 cable diagnostics. The link_speed input encodes 0 = 10, 1 = 100, 2 = 1000.
- R4: Codes 13, 14 and 15 never match. A link_speed of 3 matches no speed code, even with the link up.
- R5: Pulse mask bit 0 selects transmit strobes, bit 1 receive strobes and bit 2 collision strobes. A strobe whose bit is clear has no effect, and mask bit 3 has no effect.
- R6: A selected strobe sampled at edge N inverts the constant-on level of the LED output from edge N+1 through edge N+PULSE_CYCLES. A selected strobe that arrives during a pulse restarts the full length.
- R7: Priority order: an active pulse first, then fast blink, then slow blink, then constant-on.
- R8: A rate code of 0, 1, 2 or 3 gives a 50% duty square wave of 2, 4, 8 or 16 Hz at clock frequency CLK_HZ. All LEDs that use the same rate are in phase.
- R9: LED outputs are registered. A write accepted at edge N shows on the LEDs after edge N+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the configuration port |
| reg_addr | input | AW | Register address, AW = clog2(2*NLED+1) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0 = 10, 1 = 100, 2 = 1000 Mbit/s, 3 = none |
| st_pdown | input | 1 | PHY powered down |
| st_eee | input | 1 | Energy-efficient mode active |
| st_aneg | input | 1 | Auto-negotiation running |
| st_abist | input | 1 | Analog self-test running |
| st_cdiag | input | 1 | Cable diagnostics running |
| ev_tx | input | 1 | Single-cycle transmit activity strobe |
| ev_rx | input | 1 | Single-cycle receive activity strobe |
| ev_col | input | 1 | Single-cycle collision strobe |
| led | output | NLED | Active-high LED drives, registered |

## Verification
The bench sweeps all sixteen condition codes against link, speed and status patterns. A decoder that fills the top codes or the unused speed value with a match would light the LED where it must stay dark. It also retriggers a pulse halfway through: a stretcher that ignores a new strobe during a pulse would restore the LED a few cycles early. The bench stacks a pulse over a fast blink, and a fast blink over a slow blink. A priority chain in the wrong order would show the wrong rate, or a toggling LED where it should be steady. Each rate code is checked by counting transitions over one second of clock cycles, so a tap picked in reverse order gives the wrong count. The bench also checks that a write shows on the LEDs one cycle after it is accepted and not earlier.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

  typedef struct packed {
    logic       link;
    logic [1:0] speed;
    logic       pdown;
    logic       eee;
    logic       aneg;
    logic       abist;
    logic       cdiag;
  } phy_state_t;

  typedef struct packed {
    logic [3:0] con;
    logic [3:0] fast;
    logic [3:0] slow;
    logic [3:0] pmask;
  } led_cfg_t;

  localparam logic [7:0] GLOBAL_RST = 8'hC5;

  // Per-LED reset values repeat every four LEDs.
  function automatic logic [7:0] hi_reset(input int idx);
    case (idx % 4)
      0:       return 8'h70;
      1:       return 8'h20;
      default: return 8'h40;
    endcase
  endfunction

  function automatic logic [7:0] lo_reset(input int idx);
    case (idx % 4)
      0:       return 8'h03;
      3:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  // One-hot of the current link speed; zero without link or for speed code 3.
  function automatic logic [2:0] speed_onehot(input phy_state_t st);
    if (!st.link || st.speed == 2'd3) return 3'b000;
    return 3'b001 << st.speed;
  endfunction

  // Shared condition decoder for constant-on, fast-blink and slow-blink codes.
  function automatic logic cond_match(input logic [3:0] code, input phy_state_t st);
    logic [2:0] oh;
    oh = speed_onehot(st);
    if (code == 4'd0)           return 1'b0;
    if (code <= 4'd7)           return |(code[2:0] & oh);
    case (code)
      4'd8:    return st.pdown;
      4'd9:    return st.eee;
      4'd10:   return st.aneg;
      4'd11:   return st.abist;
      4'd12:   return st.cdiag;
      default: return 1'b0;
    endcase
  endfunction

  // Rate code 0..3 (2..16 Hz) picks divider tap 3..0.
  function automatic logic pick_wave(input logic [3:0] phase, input logic [1:0] rate);
    return phase[2'd3 - rate];
  endfunction

endpackage

// File: rtl/phy_led_regs.sv
module phy_led_regs
  import phy_led_pkg::*;
#(
  parameter int NLED = 4,
  parameter int AW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [15:0]          wdata,
  output logic [15:0]          rdata,
  output led_cfg_t [NLED-1:0]  cfg,
  output logic [1:0]           fast_rate,
  output logic [1:0]           slow_rate
);

  logic [3:0]            rate_q;
  logic [2:0]            spare_q;
  logic [NLED-1:0][7:0]  hi_q;
  logic [NLED-1:0][7:0]  lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= GLOBAL_RST[7:4];
      spare_q <= GLOBAL_RST[2:0];
      for (int i = 0; i < NLED; i++) begin
        hi_q[i] <= hi_reset(i);
        lo_q[i] <= lo_reset(i);
      end
    end else if (wr) begin
      if (addr == '0) begin
        rate_q  <= wdata[7:4];
        spare_q <= wdata[2:0];
      end
      for (int i = 0; i < NLED; i++) begin
        if (addr == AW'(1 + 2*i)) hi_q[i] <= wdata[7:0];
        if (addr == AW'(2 + 2*i)) lo_q[i] <= wdata[7:0];
      end
    end
  end

  always_comb begin
    rdata = 16'h0000;
    if (addr == '0) rdata = {8'h00, rate_q, 1'b0, spare_q};
    for (int i = 0; i < NLED; i++) begin
      if (addr == AW'(1 + 2*i)) rdata = {8'h00, hi_q[i]};
      if (addr == AW'(2 + 2*i)) rdata = {8'h00, lo_q[i]};
    end
  end

  generate
    for (genvar g = 0; g < NLED; g++) begin : g_cfg
      assign cfg[g] = '{con: hi_q[g][7:4], fast: hi_q[g][3:0],
                        slow: lo_q[g][7:4], pmask: lo_q[g][3:0]};
    end
  endgenerate

  assign fast_rate = rate_q[3:2];
  assign slow_rate = rate_q[1:0];

endmodule

// File: rtl/phy_led_timebase.sv
module phy_led_timebase #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       tick,
  output logic [3:0] phase
);

  // One tick per half period of the 16 Hz wave.
  localparam int DIV = (CLK_HZ / 32 < 1) ? 1 : CLK_HZ / 32;
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] pre_q;

  assign tick = (pre_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      phase <= '0;
    end else if (tick) begin
      pre_q <= '0;
      phase <= phase + 4'd1;
    end else begin
      pre_q <= pre_q + CW'(1);
    end
  end

endmodule

// File: rtl/phy_led_stretch.sv
module phy_led_stretch #(
  parameter int PULSE_CYCLES = 3_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);

  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (trig)          cnt_q <= PW'(PULSE_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - PW'(1);
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/phy_led_lane.sv
module phy_led_lane
  import phy_led_pkg::*;
(
  input  led_cfg_t   cfg,
  input  phy_state_t st,
  input  logic       fast_wave,
  input  logic       slow_wave,
  input  logic       pulse_on,
  input  logic [2:0] evts,
  output logic       trig,
  output logic       con_hit,
  output logic       led_next
);

  logic fast_hit;
  logic slow_hit;

  assign trig     = |(cfg.pmask & {1'b0, evts});
  assign con_hit  = cond_match(cfg.con, st);
  assign fast_hit = cond_match(cfg.fast, st);
  assign slow_hit = cond_match(cfg.slow, st);

  always_comb begin
    if (pulse_on)      led_next = !con_hit;
    else if (fast_hit) led_next = fast_wave;
    else if (slow_hit) led_next = slow_wave;
    else               led_next = con_hit;
  end

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int NLED         = 4,
  parameter int CLK_HZ       = 100_000_000,
  parameter int PULSE_CYCLES = 3_000_000,
  localparam int AW          = $clog2(2 * NLED + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  input  logic            link_up,
  input  logic [1:0]      link_speed,
  input  logic            st_pdown,
  input  logic            st_eee,
  input  logic            st_aneg,
  input  logic            st_abist,
  input  logic            st_cdiag,
  input  logic            ev_tx,
  input  logic            ev_rx,
  input  logic            ev_col,
  output logic [NLED-1:0] led
);

  led_cfg_t [NLED-1:0] cfg_w;
  logic [1:0]          fast_rate_w;
  logic [1:0]          slow_rate_w;
  logic                tick_w;
  logic [3:0]          phase_w;
  logic                fast_wave_w;
  logic                slow_wave_w;
  phy_state_t          st_w;
  logic [NLED-1:0]     trig_w;
  logic [NLED-1:0]     pact_w;
  logic [NLED-1:0]     con_w;
  logic [NLED-1:0]     next_w;

  assign st_w = '{link: link_up, speed: link_speed, pdown: st_pdown, eee: st_eee,
                  aneg: st_aneg, abist: st_abist, cdiag: st_cdiag};

  phy_led_regs #(.NLED(NLED), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .cfg       (cfg_w),
    .fast_rate (fast_rate_w),
    .slow_rate (slow_rate_w)
  );

  phy_led_timebase #(.CLK_HZ(CLK_HZ)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_w),
    .phase (phase_w)
  );

  assign fast_wave_w = pick_wave(phase_w, fast_rate_w);
  assign slow_wave_w = pick_wave(phase_w, slow_rate_w);

  generate
    for (genvar g = 0; g < NLED; g++) begin : g_led
      phy_led_lane u_lane (
        .cfg       (cfg_w[g]),
        .st        (st_w),
        .fast_wave (fast_wave_w),
        .slow_wave (slow_wave_w),
        .pulse_on  (pact_w[g]),
        .evts      ({ev_col, ev_rx, ev_tx}),
        .trig      (trig_w[g]),
        .con_hit   (con_w[g]),
        .led_next  (next_w[g])
      );

      phy_led_stretch #(.PULSE_CYCLES(PULSE_CYCLES)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig_w[g]),
        .active (pact_w[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led <= '0;
    else        led <= next_w;
  end

endmodule

// File: rtl/phy_led_ctrl_chk.sv
module phy_led_ctrl_chk #(
  parameter int NLED = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NLED-1:0] led,
  input logic [NLED-1:0] trig,
  input logic [NLED-1:0] pact,
  input logic [NLED-1:0] con_hit,
  input logic            tick,
  input logic [3:0]      phase,
  input logic [15:0]     rdata
);

  // R2: upper byte of any readback is zero
  a_r2_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[15:8] == 8'h00);

  // R8: blink phase only advances on a prescaler tick, by exactly one
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));
  a_r8_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase == $past(phase) + 4'd1);

  generate
    for (genvar g = 0; g < NLED; g++) begin : g_chk
      // R6: a selected strobe opens a pulse window
      a_r6_strobe_opens_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig[g] |=> pact[g]);
      // R7: during a pulse the LED shows the inverse of its steady level
      a_r7_pulse_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        pact[g] |=> led[g] == !$past(con_hit[g]));
    end
  endgenerate

endmodule

bind phy_led_ctrl phy_led_ctrl_chk #(.NLED(NLED)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .led     (led),
  .trig    (trig_w),
  .pact    (pact_w),
  .con_hit (con_w),
  .tick    (tick_w),
  .phase   (phase_w),
  .rdata   (reg_rdata)
);

// File: tb/phy_led_ctrl_bench.sv
module phy_led_ctrl_bench;

  localparam int TB_HZ = 320;
  localparam int PLEN  = 12;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        link_up = 0;
  logic [1:0]  link_speed = 0;
  logic        st_pdown = 0, st_eee = 0, st_aneg = 0, st_abist = 0, st_cdiag = 0;
  logic        ev_tx = 0, ev_rx = 0, ev_col = 0;
  logic [3:0]  led;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  phy_led_ctrl #(.NLED(4), .CLK_HZ(TB_HZ), .PULSE_CYCLES(PLEN)) u_phy_led_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
    .link_speed(link_speed), .st_pdown(st_pdown), .st_eee(st_eee),
    .st_aneg(st_aneg), .st_abist(st_abist), .st_cdiag(st_cdiag),
    .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_col(ev_col), .led(led)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected condition result, written as an explicit list per code.
  function automatic bit model_cond(input int code);
    bit a10, a100, a1g;
    a10  = link_up && link_speed == 2'd0;
    a100 = link_up && link_speed == 2'd1;
    a1g  = link_up && link_speed == 2'd2;
    case (code)
      1:  return a10;
      2:  return a100;
      3:  return a10 || a100;
      4:  return a1g;
      5:  return a10 || a1g;
      6:  return a100 || a1g;
      7:  return a10 || a100 || a1g;
      8:  return st_pdown;
      9:  return st_eee;
      10: return st_aneg;
      11: return st_abist;
      12: return st_cdiag;
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; reg_wr = 0; ev_tx = 0; ev_rx = 0; ev_col = 0;
    link_up = 0; link_speed = 0;
    {st_pdown, st_eee, st_aneg, st_abist, st_cdiag} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic write_reg(input int a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic read_reg(input int a, output int d);
    reg_addr = 4'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic strobe(input bit t, input bit r, input bit c);
    @(negedge clk);
    ev_tx = t; ev_rx = r; ev_col = c;
    @(negedge clk);
    ev_tx = 0; ev_rx = 0; ev_col = 0;
  endtask

  task automatic expect_led(input string req, input int idx, input int val, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(req, int'(led[idx]), val);
    end
  endtask

  // One second of samples: transitions and high cycles of one LED.
  task automatic measure(input int idx, output int trans, output int high);
    bit prev;
    trans = 0; high = 0;
    @(negedge clk);
    prev = led[idx];
    for (int k = 0; k < 320; k++) begin
      if (led[idx]) high++;
      @(negedge clk);
      if (led[idx] != prev) trans++;
      prev = led[idx];
    end
  endtask

  task automatic t_reset_values();
    int v;
    int exp_vals[9] = '{32'hC5, 32'h70, 32'h03, 32'h20, 32'h00, 32'h40, 32'h00, 32'h40, 32'h20};
    do_reset();
    for (int a = 0; a < 9; a++) begin
      read_reg(a, v);
      check("R1 reset value", v, exp_vals[a]);
    end
    check("R1 LEDs dark with no link", int'(led), 0);
  endtask

  task automatic t_map_reserved();
    int v;
    do_reset();
    write_reg(0, 16'hFFFF);
    read_reg(0, v);  check("R2 global reserved bits", v, 32'hF7);
    write_reg(1, 16'hFFFF);
    read_reg(1, v);  check("R2 LED0 high upper byte", v, 32'hFF);
    write_reg(8, 16'hAB12);
    read_reg(8, v);  check("R2 LED3 low at addr 8", v, 32'h12);
    write_reg(9, 16'hFFFF);
    read_reg(9, v);  check("R2 unused addr reads zero", v, 0);
    read_reg(15, v); check("R2 top addr reads zero", v, 0);
    read_reg(3, v);  check("R2 unused write left LED1 high", v, 32'h20);
    read_reg(7, v);  check("R2 unused write left LED3 high", v, 32'h40);
  endtask

  task automatic t_code_sweep();
    do_reset();
    for (int p = 0; p < 10; p++) begin
      @(negedge clk);
      link_up = 0; link_speed = 0;
      {st_pdown, st_eee, st_aneg, st_abist, st_cdiag} = '0;
      case (p)
        0: begin link_up = 1; link_speed = 0; end
        1: begin link_up = 1; link_speed = 1; end
        2: begin link_up = 1; link_speed = 2; end
        3: begin link_up = 1; link_speed = 3; end
        4: begin link_up = 0; link_speed = 2; end
        5: st_pdown = 1;
        6: st_eee = 1;
        7: st_aneg = 1;
        8: st_abist = 1;
        default: st_cdiag = 1;
      endcase
      for (int code = 0; code < 16; code++) begin
        write_reg(3, code << 4);
        @(negedge clk);
        if (code >= 13 || p == 3)
          check("R4 code never matches", int'(led[1]), int'(model_cond(code)));
        else
          check("R3 condition decode", int'(led[1]), int'(model_cond(code)));
      end
    end
  endtask

  task automatic t_pulse_mask();
    do_reset();
    @(negedge clk); link_up = 1; link_speed = 2;
    expect_led("R1 LED0 on with link", 0, 1, 2);
    strobe(1, 0, 0);
    expect_led("R6 tx pulse inverts", 0, 0, PLEN);
    expect_led("R6 pulse ends", 0, 1, 1);
    strobe(0, 1, 0);
    expect_led("R5 rx selected by bit 1", 0, 0, PLEN);
    expect_led("R5 rx pulse ends", 0, 1, 1);
    strobe(0, 0, 1);
    expect_led("R5 collision not selected", 0, 1, PLEN + 2);
    write_reg(2, 16'h0008);
    strobe(1, 1, 1);
    expect_led("R5 mask bit 3 has no effect", 0, 1, PLEN + 2);
    write_reg(2, 16'h0004);
    strobe(0, 0, 1);
    expect_led("R5 collision selected by bit 2", 0, 0, PLEN);
    expect_led("R5 collision pulse ends", 0, 1, 1);
  endtask

  task automatic t_pulse_restart();
    do_reset();
    @(negedge clk); link_up = 1; link_speed = 0;
    repeat (2) @(negedge clk);
    strobe(1, 0, 0);
    expect_led("R6 first pulse", 0, 0, 6);
    strobe(1, 0, 0);
    expect_led("R6 restarted pulse holds", 0, 0, PLEN);
    expect_led("R6 restarted pulse ends", 0, 1, 1);
  endtask

  task automatic t_priority();
    int tr, hi;
    do_reset();
    @(negedge clk); link_up = 1; link_speed = 1;
    write_reg(1, 16'h0077);
    strobe(1, 0, 0);
    expect_led("R7 pulse over fast blink, con on", 0, 0, PLEN);
    write_reg(1, 16'h0007);
    strobe(0, 1, 0);
    expect_led("R7 pulse over fast blink, con off", 0, 1, PLEN);
    // LED2: fast and slow both match; fast 16 Hz must win over slow 2 Hz
    write_reg(5, 16'h0007);
    write_reg(6, 16'h0070);
    measure(2, tr, hi);
    check("R7 fast wins over slow", tr, 32);
    // slow 2 Hz must win over constant-on
    write_reg(5, 16'h0070);
    measure(2, tr, hi);
    check("R7 slow wins over constant", tr, 4);
    check("R8 slow duty 50%", hi, 160);
  endtask

  task automatic t_rates();
    int tr, hi;
    do_reset();
    @(negedge clk); link_up = 1; link_speed = 2;
    for (int r = 0; r < 4; r++) begin
      write_reg(0, (r << 6) | ((3 - r) << 4));
      write_reg(5, 16'h0004);
      write_reg(6, 16'h0000);
      measure(2, tr, hi);
      check("R8 fast rate transitions", tr, 4 << r);
      check("R8 fast rate duty", hi, 160);
      write_reg(5, 16'h0000);
      write_reg(6, 16'h0040);
      measure(2, tr, hi);
      check("R8 slow rate transitions", tr, 4 << (3 - r));
    end
  endtask

  task automatic t_phase();
    int bad;
    do_reset();
    @(negedge clk); link_up = 1; link_speed = 0;
    for (int a = 1; a < 9; a++) write_reg(a, (a % 2 == 1) ? 16'h0001 : 16'h0000);
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (led != 4'h0 && led != 4'hF) bad++;
    end
    check("R8 all LEDs blink in phase", bad, 0);
  endtask

  task automatic t_write_timing();
    do_reset();
    @(negedge clk); link_up = 1; link_speed = 1;
    @(negedge clk);
    check("R9 LED1 on before write", int'(led[1]), 1);
    write_reg(3, 16'h0000);
    check("R9 no change in write cycle", int'(led[1]), 1);
    @(negedge clk);
    check("R9 change one cycle later", int'(led[1]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_values();
    t_map_reserved();
    t_code_sweep();
    t_pulse_mask();
    t_pulse_restart();
    t_priority();
    t_rates();
    t_phase();
    t_write_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule